// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This core keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A century flag extends the year. An internal prescaler divides the core clock by `TICK_DIV` to produce the one-second step. The hour byte can run in 24-hour form or in 12-hour form with an AM/PM flag, and the mode can change whenever a new time is loaded.

Software loads a new time in two steps. Byte writes fill a shadow bank. A single-cycle set strobe then copies the whole bank into the running counters and restarts the prescaler, so the first second after a load lasts a full `TICK_DIV` cycles. A software-reset level forces the counters and the prescaler to their cleared state. While that level is high, set strobes are ignored. Reads return the live counters without delay.

Top module: `bcd_rtc_core`

## Requirements
- R1: After rst_ni is released, addresses 0 to 6 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00. In address order these are seconds, minutes, hours, weekday, date, month and year.
- R2: A shadow write without a set strobe leaves the hours, date, month and year reads unchanged.
- R3: The set_i edge copies the shadow bank into the counters, and the new values are readable in the next cycle. Masks apply on the copy: seconds and minutes keep bits 6:0, hours keep bits 6:0, weekday keeps bits 2:0, date keeps bits 5:0, month keeps bit 7 and bits 4:0, and year keeps all 8 bits.
- R4: Seconds advance by one BCD count every TICK_DIV cycles after a set or a reset, and wrap from 0x59 to 0x00.
- R5: The seconds wrap advances minutes. Minutes wrap from 0x59 to 0x00 and advance the hour.
- R6: With hour bit 6 clear, the hour counts from 0x00 to 0x23 in BCD. A wrap from 0x23 to 0x00 advances the date.
- R7: With hour bit 6 set, bits 4:0 hold 1 to 12 in BCD and bit 5 is PM. Going from 11 to 12 toggles PM. Going from 12 to 1 leaves PM unchanged. Going from 11 PM to 12 AM advances the date.
- R8: Each date advance steps the weekday, and the weekday wraps from 7 to 1.
- R9: The date wraps to 0x01 after the last day of the month. February has 29 days when the year count is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31.
- R10: Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00 and toggles the century flag in month bit 7.
- R11: While srst_i is high, the counters take their cleared values on every edge and set_i has no effect.
- R12: Read address 7 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; also the prescaler reference |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Software reset level; holds the counters cleared |
| wr_en_i | input | 1 | Shadow bank byte write enable |
| wr_addr_i | input | 3 | Shadow bank byte address (0 to 6) |
| wr_data_i | input | 8 | Shadow bank write data |
| set_i | input | 1 | Strobe that copies the shadow bank into the counters |
| rd_addr_i | input | 3 | Live counter read address |
| rd_data_o | output | 8 | Live counter byte at rd_addr_i |

## Verification
The bench builds the core with TICK_DIV set to 4, so one second lasts four clocks. At that rate every carry chain can be reached within a few hundred cycles: the seconds wrap, midnight, a month end, leap and common Februaries, and the year and century wrap. The bench starts each case a few seconds before the boundary it targets and checks 12-hour noon and midnight separately. A behavioural calendar model in the bench tracks the prescaler phase, so it can follow the same one-second grid after every set strobe and software reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_REGS = 7;

  typedef enum logic [2:0] {
    A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_WDAY = 3'd3,
    A_DATE = 3'd4, A_MONTH = 3'd5, A_YEAR = 3'd6
  } rtc_addr_e;

  typedef struct packed {
    logic [2:0] wday;
    logic [5:0] date;
    logic       cent;
    logic [4:0] mon;
    logic [7:0] year;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] days_in_month(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02: return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !restart_i;
endmodule

// File: rtl/rtc_mod60.sv
module rtc_mod60 import rtc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [6:0] ld_val_i,
  input  logic       step_i,
  output logic [6:0] val_o,
  output logic       wrap_o
);
  logic [6:0] val_q;
  logic [7:0] inc;

  assign inc    = bcd_inc({1'b0, val_q});
  assign wrap_o = (val_q >= 7'h59);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clr_i)   val_q <= '0;
    else if (load_i)  val_q <= ld_val_i;
    else if (step_i)  val_q <= wrap_o ? 7'h00 : inc[6:0];
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_tod.sv
module rtc_tod import rtc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [6:0] ld_sec_i,
  input  logic [6:0] ld_min_i,
  input  logic [6:0] ld_hour_i,
  input  logic       tick_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [6:0] hour_o,
  output logic       hr_step_o,
  output logic       day_step_o
);
  localparam int unsigned NSTAGE = 2;

  logic [6:0]      ld_val [NSTAGE];
  logic [6:0]      val    [NSTAGE];
  logic [NSTAGE:0] step;
  logic [NSTAGE-1:0] wrap;

  assign ld_val[0] = ld_sec_i;
  assign ld_val[1] = ld_min_i;
  assign step[0]   = tick_i;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    rtc_mod60 u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .load_i   (load_i),
      .ld_val_i (ld_val[k]),
      .step_i   (step[k]),
      .val_o    (val[k]),
      .wrap_o   (wrap[k])
    );
    assign step[k+1] = step[k] & wrap[k];
  end

  logic [6:0] hour_q, hour_nxt;
  logic       day_end;
  logic [7:0] inc12, inc24;

  assign inc12 = bcd_inc({3'b0, hour_q[4:0]});
  assign inc24 = bcd_inc({2'b0, hour_q[5:0]});

  always_comb begin
    hour_nxt = hour_q;
    day_end  = 1'b0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nxt = {1'b1, ~hour_q[5], 5'h12};
        day_end  = hour_q[5];
      end else if (hour_q[4:0] >= 5'h12) begin
        hour_nxt = {1'b1, hour_q[5], 5'h01};
      end else begin
        hour_nxt = {1'b1, hour_q[5], inc12[4:0]};
      end
    end else if (hour_q[5:0] >= 6'h23) begin
      hour_nxt = 7'h00;
      day_end  = 1'b1;
    end else begin
      hour_nxt = {1'b0, inc24[5:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hour_q <= '0;
    else if (clr_i)          hour_q <= '0;
    else if (load_i)         hour_q <= ld_hour_i;
    else if (step[NSTAGE])   hour_q <= hour_nxt;
  end

  assign sec_o      = val[0];
  assign min_o      = val[1];
  assign hour_o     = hour_q;
  assign hr_step_o  = step[NSTAGE];
  assign day_step_o = step[NSTAGE] & day_end;
endmodule

// File: rtl/rtc_cal.sv
module rtc_cal import rtc_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  cal_t ld_i,
  input  logic day_step_i,
  output cal_t cal_o
);
  localparam cal_t CAL_CLR = '{wday: 3'd1, date: 6'h01, cent: 1'b0, mon: 5'h01, year: 8'h00};

  cal_t       cal_q, cal_nxt;
  logic [5:0] mlen;
  logic [7:0] date_inc, mon_inc, year_inc;

  assign mlen     = days_in_month(cal_q.mon, cal_q.year);
  assign date_inc = bcd_inc({2'b0, cal_q.date});
  assign mon_inc  = bcd_inc({3'b0, cal_q.mon});
  assign year_inc = bcd_inc(cal_q.year);

  always_comb begin
    cal_nxt      = cal_q;
    cal_nxt.wday = (cal_q.wday >= 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
    if (cal_q.date >= mlen) begin
      cal_nxt.date = 6'h01;
      if (cal_q.mon >= 5'h12) begin
        cal_nxt.mon = 5'h01;
        if (cal_q.year >= 8'h99) begin
          cal_nxt.year = 8'h00;
          cal_nxt.cent = ~cal_q.cent;
        end else begin
          cal_nxt.year = year_inc;
        end
      end else begin
        cal_nxt.mon = mon_inc[4:0];
      end
    end else begin
      cal_nxt.date = date_inc[5:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cal_q <= CAL_CLR;
    else if (clr_i)       cal_q <= CAL_CLR;
    else if (load_i)      cal_q <= ld_i;
    else if (day_step_i)  cal_q <= cal_nxt;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core import rtc_pkg::*; #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       set_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  logic [7:0] shadow_q [NUM_REGS];
  logic       load, sec_tick, hr_step, day_step;
  logic [6:0] sec, min, hour;
  cal_t       cal, cal_ld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) shadow_q[i] <= '0;
    end else if (wr_en_i && (32'(wr_addr_i) < NUM_REGS)) begin
      shadow_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign load = set_i & ~srst_i;

  rtc_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (srst_i | set_i),
    .tick_o    (sec_tick)
  );

  rtc_tod u_tod (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_i),
    .load_i     (load),
    .ld_sec_i   (shadow_q[A_SEC][6:0]),
    .ld_min_i   (shadow_q[A_MIN][6:0]),
    .ld_hour_i  (shadow_q[A_HOUR][6:0]),
    .tick_i     (sec_tick),
    .sec_o      (sec),
    .min_o      (min),
    .hour_o     (hour),
    .hr_step_o  (hr_step),
    .day_step_o (day_step)
  );

  assign cal_ld.wday = shadow_q[A_WDAY][2:0];
  assign cal_ld.date = shadow_q[A_DATE][5:0];
  assign cal_ld.cent = shadow_q[A_MONTH][7];
  assign cal_ld.mon  = shadow_q[A_MONTH][4:0];
  assign cal_ld.year = shadow_q[A_YEAR];

  rtc_cal u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst_i),
    .load_i     (load),
    .ld_i       (cal_ld),
    .day_step_i (day_step),
    .cal_o      (cal)
  );

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = {1'b0, sec};
      A_MIN:   rd_data_o = {1'b0, min};
      A_HOUR:  rd_data_o = {1'b0, hour};
      A_WDAY:  rd_data_o = {5'b0, cal.wday};
      A_DATE:  rd_data_o = {2'b0, cal.date};
      A_MONTH: rd_data_o = {cal.cent, 2'b0, cal.mon};
      A_YEAR:  rd_data_o = cal.year;
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       srst_i,
  input logic       set_i,
  input logic       tick_i,
  input logic       hr_step_i,
  input logic [6:0] sec_i,
  input logic [6:0] min_i,
  input logic [6:0] hour_i,
  input logic [5:0] date_i,
  input logic [7:0] sh_sec_i
);
  p_srst_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (sec_i == 7'h00 && min_i == 7'h00 && hour_i == 7'h00 && date_i == 6'h01));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !srst_i && !tick_i) |=> ($stable(sec_i) && $stable(hour_i) && $stable(date_i)));

  p_set_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !srst_i) |=> (sec_i == $past(sh_sec_i[6:0])));

  p_sec_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sec_i == 7'h59) |=> (sec_i == 7'h00));

  p_min_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sec_i == 7'h59) |=> (min_i != $past(min_i)));

  p_pm_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_step_i && hour_i[6] && hour_i[4:0] == 5'h11)
      |=> (hour_i[5] != $past(hour_i[5]) && hour_i[4:0] == 5'h12));

  p_noon_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_step_i && hour_i[6] && hour_i[4:0] == 5'h12)
      |=> (hour_i[5] == $past(hour_i[5]) && hour_i[4:0] == 5'h01));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .srst_i    (srst_i),
  .set_i     (set_i),
  .tick_i    (sec_tick),
  .hr_step_i (hr_step),
  .sec_i     (sec),
  .min_i     (min),
  .hour_i    (hour),
  .date_i    (cal.date),
  .sh_sec_i  (shadow_q[0])
);

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0, srst = 1'b0, wr_en = 1'b0, set = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit active = 0, hold = 0, done = 0;

  bcd_rtc_core #(.TICK_DIV(DIV)) u_bcd_rtc_core (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .set_i(set), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #4 clk = ~clk;

  // reference model
  int m_sec, m_min, m_hr, m_mode, m_wday, m_date, m_mon, m_yr, m_cent, m_pcnt;
  logic [7:0] sh [7];

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_clear();
    m_sec = 0; m_min = 0; m_hr = 0; m_mode = 0; m_wday = 1; m_date = 1;
    m_mon = 1; m_yr = 0; m_cent = 0; m_pcnt = 0;
  endtask

  task automatic m_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date <= mdays(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr > 99) begin m_yr = 0; m_cent ^= 1; end
  endtask

  function automatic logic [7:0] m_byte(input int a);
    int h;
    case (a)
      0: return i2b(m_sec);
      1: return i2b(m_min);
      2: begin
        if (m_mode == 0) return i2b(m_hr);
        h = m_hr % 12; if (h == 0) h = 12;
        return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | i2b(h);
      end
      3: return 8'(m_wday);
      4: return i2b(m_date);
      5: return (m_cent != 0 ? 8'h80 : 8'h00) | i2b(m_mon);
      6: return i2b(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
      for (int i = 0; i < 7; i++) sh[i] = 8'h00;
    end else begin
      if (srst) m_clear();
      else if (set) begin
        int h;
        m_sec = b2i(sh[0] & 8'h7f); m_min = b2i(sh[1] & 8'h7f);
        m_mode = sh[2][6];
        if (sh[2][6]) begin
          h = b2i(sh[2] & 8'h1f); if (h == 12) h = 0;
          m_hr = h + (sh[2][5] ? 12 : 0);
        end else m_hr = b2i(sh[2] & 8'h3f);
        m_wday = int'(sh[3][2:0]); m_date = b2i(sh[4] & 8'h3f);
        m_mon = b2i(sh[5] & 8'h1f); m_cent = sh[5][7]; m_yr = b2i(sh[6]);
        m_pcnt = 0;
      end else if (m_pcnt == DIV - 1) begin
        m_pcnt = 0; m_second();
      end else m_pcnt++;
      if (wr_en && wr_addr < 7) sh[wr_addr] = wr_data;
    end
  end

  function automatic string tag_of(input int a);
    case (a)
      0: return "R4"; 1: return "R5"; 2: return "R7"; 3: return "R8";
      4: return "R9"; 5: return "R10"; 6: return "R10"; default: return "R12";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (active && !hold) begin
      checks++;
      if (rd_data !== m_byte(int'(rd_addr))) begin
        errors++;
        $display("FAIL %s model addr %0d got %h exp %h", tag_of(int'(rd_addr)), rd_addr, rd_data, m_byte(int'(rd_addr)));
      end
      rd_addr = rd_addr + 3'd1;
    end
  end

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    hold = 1; rd_addr = a; #0.1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d got %h exp %h", tag, a, rd_data, exp);
    end
    hold = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(input logic [7:0] s, mi, h, wd, dt, mo, yr);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, wd); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  task automatic strobe();
    @(negedge clk); set = 1;
    @(negedge clk); set = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1"); chk(7, 8'h00, "R12");
    active = 1;

    // R2: shadow write without set
    load(8'h50, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    wait_cyc(6);
    chk(2, 8'h00, "R2"); chk(4, 8'h01, "R2"); chk(5, 8'h01, "R2"); chk(6, 8'h00, "R2");

    // R3 load, then R6/R8/R9/R10 new-year rollover in 24-hour mode
    strobe();
    chk(0, 8'h50, "R3"); chk(2, 8'h23, "R3"); chk(5, 8'h12, "R3"); chk(6, 8'h99, "R3");
    wait_cyc(DIV * 10);
    chk(0, 8'h00, "R4"); chk(2, 8'h00, "R6"); chk(3, 8'h01, "R8");
    chk(4, 8'h01, "R9"); chk(5, 8'h81, "R10"); chk(6, 8'h00, "R10");

    // R7: 11:59:58 PM on 28 Feb of a leap year, 12-hour mode
    load(8'h58, 8'h59, 8'h71, 8'h03, 8'h28, 8'h02, 8'h24);
    strobe();
    wait_cyc(DIV * 2);
    chk(2, 8'h52, "R7"); chk(4, 8'h29, "R9"); chk(5, 8'h02, "R9"); chk(3, 8'h04, "R8");

    // R7: 11 AM -> 12 PM, and 12 PM -> 1 PM
    load(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h05, 8'h30);
    strobe(); wait_cyc(DIV);
    chk(2, 8'h72, "R7"); chk(4, 8'h10, "R7");
    load(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h05, 8'h30);
    strobe(); wait_cyc(DIV);
    chk(2, 8'h61, "R7");

    // R9: common-year February, 30-day month
    load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    strobe(); wait_cyc(DIV);
    chk(4, 8'h01, "R9"); chk(5, 8'h03, "R9");
    load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    strobe(); wait_cyc(DIV);
    chk(4, 8'h01, "R9"); chk(5, 8'h05, "R9");

    // R10: century flag toggles back to clear; weekday 7 -> 1
    load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h92, 8'h99);
    strobe(); wait_cyc(DIV);
    chk(5, 8'h01, "R10"); chk(6, 8'h00, "R10"); chk(3, 8'h01, "R8");

    // R11: software reset holds cleared, set ignored
    load(8'h30, 8'h30, 8'h12, 8'h05, 8'h15, 8'h06, 8'h40);
    @(negedge clk); srst = 1; set = 1;
    @(negedge clk); set = 0;
    wait_cyc(2 * DIV);
    chk(0, 8'h00, "R11"); chk(2, 8'h00, "R11"); chk(4, 8'h01, "R11"); chk(6, 8'h00, "R11");
    srst = 0;
    @(negedge clk);
    chk(0, 8'h00, "R11"); chk(5, 8'h01, "R11");
    wait_cyc(DIV * 70);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule